// File: doc/BRIEF.md
# DMA Channel Stall Watchdog

This block watches one DMA channel and measures how long the channel goes without touching the internal bus. Each access strobe restarts an idle counter. The counter advances only while the channel has a transfer in progress. When the idle run reaches the interval chosen by a 3-bit code, a sticky stall flag is set. If the channel's error-interrupt enable is on, an error request is raised from that flag.

The watchdog only observes the channel. It has no output that could pause or abort a transfer, so accesses go on as soon as the channel wins the bus. Software clears the flag with a one-cycle clear pulse. The clear also restarts the idle count, so detection is armed again for a full interval. Interval code 0 switches detection off and holds the counter at zero.

Top module: `dma_stall_wdog`

## Requirements
- R1: Synchronous reset drives `stall_flag` and `err_req` to 0 and zeroes the idle count.
- R2: A nonzero `ivl_code` k selects a threshold of 2^(k+7) cycles. `stall_flag` reads 1 after the clock edge that ends the threshold-th consecutive idle active cycle since the last access, and it reads 0 one cycle earlier. With k=1 the threshold is 256; with k=7 it is 16384.
- R3: A cycle with `bus_acc`=1 zeroes the idle count. An access arriving before the threshold therefore prevents the flag, and counting starts again from zero.
- R4: The idle count advances only in cycles with `chan_active`=1. Inactive cycles pause the count without clearing it.
- R5: `ivl_code`=3'b000 never sets the flag, however long the idle time, and it zeroes the idle count.
- R6: Once set, `stall_flag` stays 1 until `stall_clr` is pulsed. Accesses and idle time do not clear it, and no new detection happens while it is set.
- R7: A cycle with `stall_clr`=1 clears the flag on the next edge and restarts the idle count. A later full idle interval sets the flag again.
- R8: When `stall_clr`=1 arrives in the same cycle as an expiry, the flag ends up set.
- R9: `err_req` equals `stall_flag` AND `err_ie`, with no added delay. Changing `err_ie` while the flag is set changes `err_req` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_active | input | 1 | A transfer is in progress on the channel |
| bus_acc | input | 1 | One-cycle strobe for each internal bus access by the channel |
| ivl_code | input | CODE_W | Interval select; 0 disables detection |
| err_ie | input | 1 | Error-interrupt enable |
| stall_clr | input | 1 | Software clear pulse for the stall flag |
| stall_flag | output | 1 | Sticky stall status |
| err_req | output | 1 | Error interrupt request |

## Verification
Two events can land in the same cycle: the software clear of the flag and a fresh expiry of the idle count.

- **Provoking the collision:** The bench runs 255 idle active cycles after a clear and an access. It then holds `stall_clr` high through the cycle in which the 256th idle cycle completes.
- **Judging it:** The flag must read 1 after that edge.
- **Follow-up:** A later clear alone must bring the flag back to 0.

The nearby orderings are also exercised: an access in the same cycle as a clear, an access while the flag is held, and a pause of activity just before expiry.

// File: rtl/dma_stall_wdog_pkg.sv
`timescale 1ns/1ps
package dma_stall_wdog_pkg;

    // Per-cycle control fed to the idle counter
    typedef struct packed {
        logic enable;   // nonzero interval code
        logic run;      // channel has a transfer in progress
        logic access;   // bus access strobe this cycle
        logic clear;    // software clear this cycle
    } idle_ctl_t;

    // Events produced by the idle counter
    typedef struct packed {
        logic expire;   // threshold reached while armed
        logic at_sat;   // count is held at the threshold
    } idle_evt_t;

    // Exponent of the threshold for a nonzero interval code
    function automatic int unsigned thr_exp(input int unsigned code,
                                            input int unsigned base);
        return base + code;
    endfunction

    // Counter width able to hold the largest threshold
    function automatic int unsigned cnt_width(input int unsigned code_w,
                                              input int unsigned base);
        return thr_exp((1 << code_w) - 1, base) + 1;
    endfunction

endpackage

// File: rtl/wdg_thr_decode.sv
`timescale 1ns/1ps
module wdg_thr_decode
    import dma_stall_wdog_pkg::*;
#(
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned BASE_SHIFT = 7,
    localparam int unsigned CNT_W     = cnt_width(CODE_W, BASE_SHIFT),
    localparam int unsigned NCODES    = 1 << CODE_W
) (
    input  logic [CODE_W-1:0] code,
    output logic              enable,
    output logic [CNT_W-1:0]  thr
);
    logic [CNT_W-1:0] lut [NCODES];

    assign lut[0] = '0;
    for (genvar g = 1; g < NCODES; g++) begin : g_thr
        assign lut[g] = CNT_W'(1) << thr_exp(g, BASE_SHIFT);
    end

    assign enable = (code != '0);
    assign thr    = lut[code];
endmodule

// File: rtl/wdg_idle_ctr.sv
`timescale 1ns/1ps
module wdg_idle_ctr
    import dma_stall_wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  idle_ctl_t        ctl,
    input  logic [CNT_W-1:0] thr,
    input  logic             armed,
    output idle_evt_t        evt
);
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic [CNT_W:0]   cnt_nxt_wide;
    logic             reach;

    always_comb begin
        cnt_nxt_wide = {1'b0, cnt_q} + 1'b1;
        reach        = (cnt_nxt_wide >= {1'b0, thr});
        cnt_inc      = reach ? thr : cnt_nxt_wide[CNT_W-1:0];

        evt.expire = ctl.enable && ctl.run && !ctl.access && armed && reach;
        evt.at_sat = ctl.enable && (cnt_q >= thr);

        if (ctl.access || ctl.clear || !ctl.enable) begin
            cnt_d = '0;
        end else if (ctl.run) begin
            cnt_d = cnt_inc;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    AST_ACCESS_RESTART: assert property (@(posedge clk) disable iff (rst)
        ctl.access |=> (cnt_q == '0)); // R3

    AST_IDLE_PAUSE: assert property (@(posedge clk) disable iff (rst)
        (ctl.enable && !ctl.run && !ctl.access && !ctl.clear) |=> $stable(cnt_q)); // R4

    AST_DISABLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ctl.enable |=> (cnt_q == '0)); // R5

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (cnt_q == '0)); // R1
endmodule

// File: rtl/wdg_stall_flag.sv
`timescale 1ns/1ps
module wdg_stall_flag
    import dma_stall_wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  idle_evt_t evt,
    input  logic      clr,
    input  logic      ie,
    output logic      flag,
    output logic      req
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)             flag_q <= 1'b0;
        else if (evt.expire) flag_q <= 1'b1;   // set beats clear
        else if (clr)        flag_q <= 1'b0;
    end

    assign flag = flag_q;
    assign req  = flag_q & ie;

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (evt.expire && clr) |=> flag_q); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt.expire) |=> !flag_q); // R7
endmodule

// File: rtl/dma_stall_wdog.sv
`timescale 1ns/1ps
module dma_stall_wdog
    import dma_stall_wdog_pkg::*;
#(
    parameter int unsigned CODE_W     = 3,
    parameter int unsigned BASE_SHIFT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chan_active,
    input  logic              bus_acc,
    input  logic [CODE_W-1:0] ivl_code,
    input  logic              err_ie,
    input  logic              stall_clr,
    output logic              stall_flag,
    output logic              err_req
);
    localparam int unsigned CNT_W = cnt_width(CODE_W, BASE_SHIFT);

    logic             enable;
    logic [CNT_W-1:0] thr;
    idle_ctl_t        ctl;
    idle_evt_t        evt;

    wdg_thr_decode #(
        .CODE_W     (CODE_W),
        .BASE_SHIFT (BASE_SHIFT)
    ) u_dec (
        .code   (ivl_code),
        .enable (enable),
        .thr    (thr)
    );

    always_comb begin
        ctl.enable = enable;
        ctl.run    = chan_active;
        ctl.access = bus_acc;
        ctl.clear  = stall_clr;
    end

    wdg_idle_ctr #(
        .CNT_W (CNT_W)
    ) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .ctl   (ctl),
        .thr   (thr),
        .armed (!stall_flag),
        .evt   (evt)
    );

    wdg_stall_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .clr  (stall_clr),
        .ie   (err_ie),
        .flag (stall_flag),
        .req  (err_req)
    );

    AST_OFF_NO_SET: assert property (@(posedge clk) disable iff (rst)
        ((ivl_code == '0) && !stall_flag) |=> !stall_flag); // R5

    AST_REQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !err_ie |-> !err_req); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!stall_flag && !err_req)); // R1

    AST_SAT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (evt.at_sat && chan_active && !bus_acc && !stall_clr) |=> stall_flag); // R2
endmodule

// File: tb/tb_dma_stall_wdog.sv
`timescale 1ns/1ps
module tb_dma_stall_wdog;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chan_active = 1'b0;
    logic       bus_acc = 1'b0;
    logic [2:0] ivl_code = 3'd0;
    logic       err_ie = 1'b0;
    logic       stall_clr = 1'b0;
    logic       stall_flag, err_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    dma_stall_wdog dut (
        .clk         (clk),
        .rst         (rst),
        .chan_active (chan_active),
        .bus_acc     (bus_acc),
        .ivl_code    (ivl_code),
        .err_ie      (err_ie),
        .stall_clr   (stall_clr),
        .stall_flag  (stall_flag),
        .err_req     (err_req)
    );

    typedef struct packed {
        logic [2:0]  code;
        logic        act;
        logic        strb;
        logic        clr;
        logic        ie;
        logic [15:0] n;
        logic        eflag;
        logic        ereq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VEC [NV] = '{
        '{3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1,    1'b0, 1'b0, 4'd3}, // R3 start from access
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd255,  1'b0, 1'b0, 4'd2}, // R2 one short
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1,    1'b1, 1'b1, 4'd2}, // R2 expiry at 256
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    1'b1, 1'b0, 4'd9}, // R9 enable off
        '{3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd3,    1'b1, 1'b0, 4'd6}, // R6 access keeps flag
        '{3'd1, 1'b1, 1'b1, 1'b1, 1'b1, 16'd1,    1'b0, 1'b0, 4'd7}, // R7 clear
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b1, 16'd255,  1'b0, 1'b0, 4'd7}, // R7 rearmed, one short
        '{3'd1, 1'b1, 1'b0, 1'b1, 1'b1, 16'd1,    1'b1, 1'b1, 4'd8}, // R8 clear meets expiry
        '{3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1,    1'b0, 1'b0, 4'd7}, // R7 clear again
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd600,  1'b0, 1'b0, 4'd4}, // R4 inactive
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd255,  1'b0, 1'b0, 4'd4}, // R4 active one short
        '{3'd1, 1'b0, 1'b0, 1'b0, 1'b0, 16'd10,   1'b0, 1'b0, 4'd4}, // R4 pause
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    1'b1, 1'b0, 4'd4}, // R4 resume expires
        '{3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1,    1'b0, 1'b0, 4'd7}, // R7
        '{3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 16'd3000, 1'b0, 1'b0, 4'd5}, // R5 disabled
        '{3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 16'd511,  1'b0, 1'b0, 4'd2}, // R2 code 2 one short
        '{3'd2, 1'b1, 1'b0, 1'b0, 1'b1, 16'd1,    1'b1, 1'b1, 4'd2}, // R2 code 2 at 512
        '{3'd2, 1'b1, 1'b1, 1'b1, 1'b1, 16'd1,    1'b0, 1'b0, 4'd7}, // R7
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd200,  1'b0, 1'b0, 4'd3}, // R3 partial
        '{3'd1, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1,    1'b0, 1'b0, 4'd3}, // R3 access restarts
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd255,  1'b0, 1'b0, 4'd3}, // R3 full interval again
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    1'b1, 1'b0, 4'd3}, // R3 expiry
        '{3'd1, 1'b1, 1'b1, 1'b1, 1'b0, 16'd1,    1'b0, 1'b0, 4'd7}, // R7
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd200,  1'b0, 1'b0, 4'd5}, // R5 partial
        '{3'd0, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    1'b0, 1'b0, 4'd5}, // R5 disable zeroes
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd255,  1'b0, 1'b0, 4'd5}, // R5 full interval needed
        '{3'd1, 1'b1, 1'b0, 1'b0, 1'b0, 16'd1,    1'b1, 1'b0, 4'd5}  // R5 expiry
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input int r,
                         input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R%0d %s actual=%0b expected=%0b", r, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        #1;
        repeat (3) step();
        rst = 1'b0;
        // R1: reset state
        check(stall_flag, 1'b0, 1, "stall_flag after reset");
        check(err_req,    1'b0, 1, "err_req after reset");

        for (int i = 0; i < NV; i++) begin
            ivl_code    = VEC[i].code;
            chan_active = VEC[i].act;
            bus_acc     = VEC[i].strb;
            stall_clr   = VEC[i].clr;
            err_ie      = VEC[i].ie;
            #1;
            repeat (int'(VEC[i].n)) step();
            check(stall_flag, VEC[i].eflag, int'(VEC[i].req), $sformatf("row %0d flag", i));
            check(err_req,    VEC[i].ereq,  int'(VEC[i].req), $sformatf("row %0d req", i));
        end
        bus_acc = 1'b0;
        stall_clr = 1'b0;

        // R9: err_req follows err_ie with no delay
        ivl_code = 3'd1; chan_active = 1'b1; err_ie = 1'b0;
        repeat (260) step();
        check(stall_flag, 1'b1, 9, "flag before enable toggle");
        err_ie = 1'b1; #1;
        check(err_req, 1'b1, 9, "err_req immediate on enable");
        err_ie = 1'b0; #1;
        check(err_req, 1'b0, 9, "err_req immediate off");

        // R2: largest code, threshold 16384
        bus_acc = 1'b1; stall_clr = 1'b1; ivl_code = 3'd7;
        step();
        bus_acc = 1'b0; stall_clr = 1'b0;
        repeat (16383) step();
        check(stall_flag, 1'b0, 2, "code7 one short");
        step();
        check(stall_flag, 1'b1, 2, "code7 expiry");

        // R1: reset while the flag is set
        err_ie = 1'b1;
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(stall_flag, 1'b0, 1, "flag after mid-run reset");
        check(err_req,    1'b0, 1, "req after mid-run reset");
        ivl_code = 3'd1;
        repeat (255) step();
        check(stall_flag, 1'b0, 1, "count restarted by reset");
        step();
        check(stall_flag, 1'b1, 1, "expiry after reset");

        finish_run();
    end
endmodule